// File: doc/BRIEF.md
# Multichannel Event Readout Concentrator

This block gathers timing events from sixteen channels and forwards them on a single 16-bit output stream. Each channel receives an event as a write strobe with four 16-bit time registers. A global setting says how many of those registers, one to four, belong to the event, and that length is stored with the event. Every channel keeps its events in a small local buffer with a fixed number of event slots.

A scanner visits the channels in a fixed ring order. When it finds a channel with a pending event, it pushes that whole event out before moving to the next channel. Nothing downstream has to ask for data. An event leaves as a header word followed by its data words. The data words are taken from the channel's registers by a two-bit register select that the scanner drives.

An output FIFO decouples the scanner from the output handshake. In test mode this FIFO is bypassed and words go straight to the port. If a channel's buffer is full, a new event is dropped, and the next event that channel does store is marked with the error flag.

Top module: `evt_readout_hub`

## Requirements
- R1: A pulse on `ch_wr[c]` stores one event for channel c. Its length N is `cfg_words_m1`+1 (1 to 4), taken from `cfg_words_m1` in the cycle of the write.
- R2: An event leaves as one header word followed by N data words. Header bit 15 is the error flag, bits 14:11 are the channel index, bits 10:9 are N-1, and bits 8:0 are zero.
- R3: Data word k (k = 0..N-1) equals register k of the stored event, where register k is `ch_time[(c*4+k)*16 +: 16]`. The words go out in increasing k.
- R4: Each channel returns its events in write order. Every stored event is output exactly once, and the buffer holds `EVT_DEPTH` events.
- R5: Channels are served in ascending index order, wrapping from 15 to 0, starting after the channel served last. Each event goes out complete, with no words from another channel in between.
- R6: Output words transfer when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged.
- R7: A write to a channel whose buffer holds `EVT_DEPTH` events is discarded. The next event that channel accepts carries error flag 1, and later events carry 0 again.
- R8: In normal mode (`test_mode`=0), up to `OFIFO_DEPTH` words are absorbed while `out_ready` is low, so channel buffers keep draining. In test mode the FIFO is bypassed, and nothing leaves a channel buffer until the output accepts it.
- R9: During reset and in the first cycle after it, `out_valid` is 0.
- R10: With no writes after reset, `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| test_mode | input | 1 | 1 bypasses the output FIFO |
| cfg_words_m1 | input | 2 | Event length minus one, used for new writes |
| ch_wr | input | 16 | Per-channel event write strobe |
| ch_time | input | 1024 | Four 16-bit time registers per channel; channel c register k at bit (c*4+k)*16 |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts a word |
| out_data | output | 16 | Output word, header or data |

## Verification
On every cycle, the assertions check that the output holds steady under back-pressure and that header padding is zero, using a header tracker built from the output stream alone. They also check that at most one channel is released per cycle, that an empty buffer is never popped, and that the output is idle right after reset. What only the bench's scenarios can show is that the right data arrives in the right order: register selection, per-channel ordering, the ring order across channels, which event gets the error flag after an overflow, and how the bypass changes buffer drain under back-pressure.

// File: rtl/evr_pkg.sv
package evr_pkg;
   typedef enum logic [1:0] {SC_HUNT, SC_HDR, SC_DATA} scan_st_e;

   function automatic logic [15:0] mk_hdr(input logic err, input logic [3:0] ch,
                                          input logic [1:0] len_m1);
      return {err, ch, len_m1, 9'd0};
   endfunction
endpackage

// File: rtl/evr_chan_buf.sv
module evr_chan_buf #(
   parameter int WORD_W    = 16,
   parameter int EVT_DEPTH = 16,
   localparam int PW = $clog2(EVT_DEPTH),
   localparam int EW = 4 * WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [1:0]        wr_len_m1,
   input  logic [EW-1:0]     wr_regs,
   input  logic              pop,
   input  logic [1:0]        sel,
   output logic              nempty,
   output logic              head_err,
   output logic [1:0]        head_len_m1,
   output logic [WORD_W-1:0] rd_word
);
   logic [EW-1:0] regs_q [EVT_DEPTH];
   logic [2:0]    meta_q [EVT_DEPTH];
   logic [PW-1:0] wp, rp;
   logic [PW:0]   cnt;
   logic          pend_err, full, acc;

   assign full   = (cnt == (PW+1)'(EVT_DEPTH));
   assign acc    = wr && !full;
   assign nempty = (cnt != '0);

   always_ff @(posedge clk) begin
      if (acc) begin
         regs_q[wp] <= wr_regs;
         meta_q[wp] <= {pend_err, wr_len_m1};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp       <= '0;
         rp       <= '0;
         cnt      <= '0;
         pend_err <= 1'b0;
      end else begin
         if (acc) wp <= wp + 1'b1;
         if (pop) rp <= rp + 1'b1;
         cnt <= cnt + (PW+1)'(acc) - (PW+1)'(pop);
         if (wr && full) pend_err <= 1'b1;
         else if (acc)   pend_err <= 1'b0;
      end
   end

   assign head_err    = meta_q[rp][2];
   assign head_len_m1 = meta_q[rp][1:0];
   assign rd_word     = regs_q[rp][int'(sel)*WORD_W +: WORD_W];
endmodule

// File: rtl/evr_scan.sv
module evr_scan import evr_pkg::*; #(
   parameter int NCH    = 16,
   parameter int WORD_W = 16,
   localparam int CW = $clog2(NCH)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NCH-1:0]        ch_nempty,
   input  logic [NCH-1:0]        ch_err,
   input  logic [2*NCH-1:0]      ch_len,
   input  logic [NCH*WORD_W-1:0] ch_word,
   output logic [NCH-1:0]        ch_pop,
   output logic [1:0]            sel,
   output logic                  s_valid,
   output logic [WORD_W-1:0]     s_data,
   input  logic                  s_ready
);
   scan_st_e      st;
   logic [CW-1:0] ptr, ptr_nx;
   logic [1:0]    widx, cur_len;
   logic          last;

   assign cur_len = ch_len[int'(ptr)*2 +: 2];
   assign ptr_nx  = (ptr == CW'(NCH-1)) ? '0 : ptr + 1'b1;
   assign last    = (widx == cur_len);
   assign sel     = widx;
   assign s_valid = (st != SC_HUNT);
   assign s_data  = (st == SC_HDR) ? mk_hdr(ch_err[ptr], 4'(ptr), cur_len)
                                   : ch_word[int'(ptr)*WORD_W +: WORD_W];

   always_comb begin
      ch_pop = '0;
      if (st == SC_DATA && s_ready && last) ch_pop[ptr] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= SC_HUNT;
         ptr  <= '0;
         widx <= '0;
      end else begin
         case (st)
            SC_HUNT: if (ch_nempty[ptr]) st <= SC_HDR;
                     else                ptr <= ptr_nx;
            SC_HDR:  if (s_ready) begin
                        st   <= SC_DATA;
                        widx <= '0;
                     end
            SC_DATA: if (s_ready) begin
                        if (last) begin
                           st  <= SC_HUNT;
                           ptr <= ptr_nx;
                        end else begin
                           widx <= widx + 1'b1;
                        end
                     end
            default: st <= SC_HUNT;
         endcase
      end
   end
endmodule

// File: rtl/evr_out_stage.sv
module evr_out_stage #(
   parameter int WORD_W      = 16,
   parameter int OFIFO_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              test_mode,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data
);
   if (OFIFO_DEPTH == 0) begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
   end else begin : g_fifo
      localparam int AW = $clog2(OFIFO_DEPTH);
      logic [WORD_W-1:0] mem [OFIFO_DEPTH];
      logic [AW-1:0]     wp, rp;
      logic [AW:0]       cnt;
      logic              empty, full, bypass, push, pop;

      assign empty     = (cnt == '0);
      assign full      = (cnt == (AW+1)'(OFIFO_DEPTH));
      assign bypass    = test_mode && empty;
      assign in_ready  = bypass ? out_ready : !full;
      assign push      = in_valid && !bypass && !full;
      assign pop       = !bypass && !empty && out_ready;
      assign out_valid = bypass ? in_valid : !empty;
      assign out_data  = bypass ? in_data : mem[rp];

      always_ff @(posedge clk) begin
         if (push) mem[wp] <= in_data;
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
         end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
         end
      end
   end
endmodule

// File: rtl/evt_readout_hub.sv
module evt_readout_hub #(
   parameter int NCH         = 16,
   parameter int WORD_W      = 16,
   parameter int EVT_DEPTH   = 16,
   parameter int OFIFO_DEPTH = 8,
   localparam int RW = 4 * WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              test_mode,
   input  logic [1:0]        cfg_words_m1,
   input  logic [NCH-1:0]    ch_wr,
   input  logic [NCH*RW-1:0] ch_time,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data
);
   if (WORD_W != 16) begin : g_bad_width
      $error("evt_readout_hub: header layout needs WORD_W == 16");
   end
   if (NCH < 2 || NCH > 16) begin : g_bad_nch
      $error("evt_readout_hub: NCH must lie in 2..16");
   end
   if (EVT_DEPTH < 2 || (EVT_DEPTH & (EVT_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("evt_readout_hub: EVT_DEPTH must be a power of two >= 2");
   end
   if (OFIFO_DEPTH != 0 && (OFIFO_DEPTH & (OFIFO_DEPTH - 1)) != 0) begin : g_bad_ofifo
      $error("evt_readout_hub: OFIFO_DEPTH must be 0 or a power of two");
   end

   logic [NCH-1:0]        ch_nempty, ch_err, ch_pop;
   logic [2*NCH-1:0]      ch_len;
   logic [NCH*WORD_W-1:0] ch_word;
   logic [1:0]            cmd_sel;
   logic                  s_valid, s_ready;
   logic [WORD_W-1:0]     s_data;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      evr_chan_buf #(.WORD_W(WORD_W), .EVT_DEPTH(EVT_DEPTH)) u_buf (
         .clk        (clk),
         .rst        (rst),
         .wr         (ch_wr[c]),
         .wr_len_m1  (cfg_words_m1),
         .wr_regs    (ch_time[c*RW +: RW]),
         .pop        (ch_pop[c]),
         .sel        (cmd_sel),
         .nempty     (ch_nempty[c]),
         .head_err   (ch_err[c]),
         .head_len_m1(ch_len[c*2 +: 2]),
         .rd_word    (ch_word[c*WORD_W +: WORD_W])
      );
   end

   evr_scan #(.NCH(NCH), .WORD_W(WORD_W)) u_scan (
      .clk      (clk),
      .rst      (rst),
      .ch_nempty(ch_nempty),
      .ch_err   (ch_err),
      .ch_len   (ch_len),
      .ch_word  (ch_word),
      .ch_pop   (ch_pop),
      .sel      (cmd_sel),
      .s_valid  (s_valid),
      .s_data   (s_data),
      .s_ready  (s_ready)
   );

   evr_out_stage #(.WORD_W(WORD_W), .OFIFO_DEPTH(OFIFO_DEPTH)) u_out (
      .clk      (clk),
      .rst      (rst),
      .test_mode(test_mode),
      .in_valid (s_valid),
      .in_ready (s_ready),
      .in_data  (s_data),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_data (out_data)
   );
endmodule

// File: rtl/evr_readout_chk.sv
module evr_readout_chk #(
   parameter int NCH    = 16,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              test_mode,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_data,
   input logic [NCH-1:0]    ch_pop,
   input logic [NCH-1:0]    ch_nempty
);
   logic       expect_hdr;
   logic [2:0] rem;

   always_ff @(posedge clk) begin
      if (rst) begin
         expect_hdr <= 1'b1;
         rem        <= '0;
      end else if (out_valid && out_ready) begin
         if (expect_hdr) begin
            expect_hdr <= 1'b0;
            rem        <= {1'b0, out_data[10:9]} + 3'd1;
         end else begin
            rem <= rem - 3'd1;
            if (rem == 3'd1) expect_hdr <= 1'b1;
         end
      end
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (!$stable(test_mode) || (out_valid && $stable(out_data))));  // R6
   AST_HDR_PAD: assert property (@(posedge clk) disable iff (rst)
      (out_valid && expect_hdr) |-> (out_data[8:0] == 9'd0));  // R2
   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
      ((ch_pop & ~ch_nempty) == '0));  // R4
   AST_ONE_POP: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ch_pop));  // R5
   AST_IDLE_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid);  // R9
endmodule

bind evt_readout_hub evr_readout_chk #(.NCH(NCH), .WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .test_mode(test_mode),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data),
   .ch_pop   (ch_pop),
   .ch_nempty(ch_nempty)
);

// File: tb/test_evt_readout_hub.sv
module test_evt_readout_hub;
   localparam int NCH = 16;
   localparam int EVT_DEPTH = 16;

   logic              clk = 1'b0;
   logic              rst;
   logic              test_mode;
   logic [1:0]        cfg_words_m1;
   logic [NCH-1:0]    ch_wr;
   logic [NCH*64-1:0] ch_time;
   logic              out_valid, out_ready;
   logic [15:0]       out_data;

   evt_readout_hub i_evt_readout_hub (
      .clk(clk), .rst(rst), .test_mode(test_mode), .cfg_words_m1(cfg_words_m1),
      .ch_wr(ch_wr), .ch_time(ch_time), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   event smp;
   initial forever begin
      #4 clk = 1'b1;
      #4 clk = 1'b0;
      #2 -> smp;
      #0;
   end

   int n_chk = 0, n_err = 0, n_seen = 0, n_idle_valid = 0;
   bit finished = 0;
   logic [66:0] exp_q [NCH][$];
   int ord_q[$];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   // monitor: decodes the stream and compares against the per-channel model
   bit          m_hdr = 1;
   int          m_ch, m_len, m_idx;
   logic [66:0] m_evt;
   bit          prev_stall = 0;
   logic [15:0] prev_data;
   logic        prev_mode;
   always @(smp) begin
      if (!rst) begin
         if (prev_stall && prev_mode == test_mode)
            chk(out_valid && out_data == prev_data, "R6 stall hold", out_data, prev_data);
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         prev_mode  = test_mode;
         if (out_valid && out_ready) begin
            if (m_hdr) begin
               m_ch  = int'(out_data[14:11]);
               m_len = int'(out_data[10:9]);
               chk(out_data[8:0] == 0, "R2 header padding", out_data, 0);
               ord_q.push_back(m_ch);
               n_seen++;
               if (exp_q[m_ch].size() == 0) begin
                  chk(0, "R4 unexpected event", m_ch, -1);
                  m_evt = '0;
               end else begin
                  m_evt = exp_q[m_ch].pop_front();
                  chk(out_data[15] == m_evt[66], "R7 error flag", out_data[15], m_evt[66]);
                  chk(m_len == int'(m_evt[65:64]), "R1 event length", m_len, m_evt[65:64]);
               end
               m_idx = 0;
               m_hdr = 0;
            end else begin
               chk(out_data == m_evt[m_idx*16 +: 16], "R3 data word", out_data, m_evt[m_idx*16 +: 16]);
               m_idx++;
               if (m_idx > m_len) m_hdr = 1;
            end
         end
      end
   end

   // one write cycle to all channels in mask; call at a negedge
   task automatic put(input logic [NCH-1:0] mask, input int lm1, input bit err, input bit keep);
      cfg_words_m1 = 2'(lm1);
      for (int c = 0; c < NCH; c++) begin
         if (mask[c]) begin
            logic [63:0] d;
            d = {$urandom(), $urandom()};
            ch_time[c*64 +: 64] = d;
            if (keep) exp_q[c].push_back({err, 2'(lm1), d});
         end
      end
      ch_wr = mask;
      @(negedge clk);
      ch_wr = '0;
   endtask

   task automatic drain();
      out_ready = 1'b1;
      repeat (300) @(negedge clk);
   endtask

   initial begin
      #1200000;
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      void'($urandom(32'd20250927));
      rst = 1'b1; test_mode = 1'b0; cfg_words_m1 = 2'd0; ch_wr = '0; ch_time = '0; out_ready = 1'b0;
      repeat (3) @(smp);
      chk(out_valid == 1'b0, "R9 valid in reset", out_valid, 0);
      @(negedge clk);
      rst = 1'b0;
      out_ready = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(smp);
         if (out_valid) n_idle_valid++;
      end
      chk(n_idle_valid == 0, "R10 idle after reset", n_idle_valid, 0);

      // every length, normal mode
      @(negedge clk);
      for (int l = 0; l < 4; l++) put(NCH'(1) << (l*4+1), l, 0, 1);
      drain();

      // ring order: 2 held at header, then 5 and 1 queued
      test_mode = 1'b1; out_ready = 1'b0;
      put(NCH'(1) << 2, 1, 0, 1);
      for (int i = 0; i < 60 && !out_valid; i++) @(negedge clk);
      put((NCH'(1) << 5) | (NCH'(1) << 1), 0, 0, 1);
      ord_q.delete();
      drain();
      chk(ord_q.size() == 3, "R5 event count", ord_q.size(), 3);
      if (ord_q.size() == 3) begin
         chk(ord_q[0] == 2, "R5 first channel", ord_q[0], 2);
         chk(ord_q[1] == 5, "R5 second channel", ord_q[1], 5);
         chk(ord_q[2] == 1, "R5 wrapped channel", ord_q[2], 1);
      end

      // normal mode under back-pressure: FIFO absorbs, nothing dropped
      test_mode = 1'b0; out_ready = 1'b0;
      n_seen = 0;
      for (int i = 0; i <= EVT_DEPTH; i++) put(NCH'(1) << 9, 0, 0, 1);
      drain();
      chk(n_seen == EVT_DEPTH + 1, "R8 normal mode keeps all", n_seen, EVT_DEPTH + 1);
      chk(exp_q[9].size() == 0, "R8 queue empty", exp_q[9].size(), 0);

      // test mode under back-pressure: buffer fills, extra writes dropped
      test_mode = 1'b1; out_ready = 1'b0;
      n_seen = 0;
      for (int i = 0; i < EVT_DEPTH; i++) put(NCH'(1) << 9, 0, 0, 1);
      put(NCH'(1) << 9, 3, 0, 0);
      put(NCH'(1) << 9, 2, 0, 0);
      drain();
      chk(n_seen == EVT_DEPTH, "R7 full buffer drops", n_seen, EVT_DEPTH);
      put(NCH'(1) << 9, 1, 1, 1);
      put(NCH'(1) << 9, 2, 0, 1);
      drain();
      chk(n_seen == EVT_DEPTH + 2, "R7 flagged event delivered", n_seen, EVT_DEPTH + 2);

      // random traffic in both modes
      for (int m = 0; m < 2; m++) begin
         test_mode = 1'(m);
         for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            out_ready = ($urandom() % 4) != 0;
            if (($urandom() % 16) == 0) begin
               int c;
               int l;
               logic [63:0] d;
               c = int'($urandom() % NCH);
               l = int'($urandom() % 4);
               d = {$urandom(), $urandom()};
               ch_time[c*64 +: 64] = d;
               cfg_words_m1 = 2'(l);
               exp_q[c].push_back({1'b0, 2'(l), d});
               ch_wr = NCH'(1) << c;
            end else begin
               ch_wr = '0;
            end
         end
         @(negedge clk);
         ch_wr = '0;
         drain();
      end

      for (int c = 0; c < NCH; c++)
         chk(exp_q[c].size() == 0, "R4 all events delivered", exp_q[c].size(), 0);
      chk(m_hdr == 1, "R5 stream ends on event boundary", m_hdr, 1);
      finish_run();
   end
endmodule